// File: doc/BRIEF.md
# Serial Presence Data Configuration Decoder

This block takes in the 64 checksummed bytes of a memory module's serial presence data and turns them into the settings that a memory controller needs. The bytes arrive one per cycle on a valid strobe, starting at byte 0. The block counts the position of each byte itself. While the stream comes in, it keeps an 8-bit running sum and stores the fields that describe the module's geometry, refresh rate and CAS latency support.

When the last byte has been accepted, the block presents its results and holds them. The results are:
- a refresh-timer code;
- a CAS latency, chosen by a selectable priority and raised to a floor;
- the base-2 logarithm of the internal bank count;
- clamped row and column address counts;
- the chip-select count and the data width;
- the size of one side and the total size;
- a vector of warning flags.

A one-cycle done pulse marks the moment the results become valid. Bytes that arrive after that are ignored. A start pulse clears everything for a new module.

Top module: `spd_cfg_decoder`

## Requirements
- R1: After reset, or after a cycle with `start_i` high, every result output reads zero and `done_o` stays low until all 64 bytes of a new stream have been accepted. When `start_i` and `byte_vld_i` are high in the same cycle, the byte is dropped. A partly received stream is discarded by `start_i`.
- R2: `done_o` is high for exactly one cycle: the cycle that follows the acceptance of byte 63. The results are valid from that cycle on and keep their values until the next `start_i`.
- R3: Once byte 63 has been accepted, further valid bytes change no output and raise no further `done_o`, until `start_i` is seen.
- R4: `warn_o[0]` is set when the sum of bytes 0 to 62, taken modulo 256, differs from byte 63.
- R5: The row count is the low nibble of byte 3 and the column count is the low nibble of byte 4. The chip-select count is the low nibble of byte 5. Rows above 14 are clamped to 14 and set `warn_o[4]`. Columns above 11 are clamped to 11 and set `warn_o[5]`.
- R6: `data_width_o` is byte 6 plus 256 times byte 7. `warn_o[1]` is set unless the width is 64 or 72.
- R7: The low 7 bits of byte 12 choose `refresh_code_o`:
  - 1 gives 0x07;
  - 2 gives 0x0F;
  - 3 gives 0x43;
  - 4 gives 0x87;
  - 5 gives 0xFF;
  - 0 or any other value gives 0x21.
- R8: `bank_log2_o` is 1, 2 or 3 when byte 17 is 2, 4 or 8. It is 0 for any other value of byte 17.
- R9: The CAS latency comes from bits 0, 1 and 2 of byte 18, which stand for latencies 1, 2 and 3.
  - With `cas_pess_i` low, the lowest set bit wins.
  - With `cas_pess_i` high, the highest set bit wins.
  - If none of the three bits is set, the latency is 3 and `warn_o[2]` is set.
  - The mode is sampled when byte 63 is accepted.
- R10: A chosen CAS latency below 2 is raised to 2, and `warn_o[3]` is set.
- R11: `side_size_o` is 2 raised to the power (rows + columns + `bank_log2_o` + 3), using the clamped rows and columns. `total_size_o` is `side_size_o` times the chip-select count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the index, the sum and the stored fields |
| byte_vld_i | input | 1 | A presence-data byte is offered this cycle |
| byte_i | input | 8 | Presence-data byte |
| cas_pess_i | input | 1 | 1: highest supported CAS latency wins; 0: lowest wins |
| done_o | output | 1 | One-cycle pulse when the results become valid |
| refresh_code_o | output | 8 | Refresh-timer code |
| cas_lat_o | output | 2 | CAS latency, 2 or 3 |
| bank_log2_o | output | 2 | Base-2 log of the internal bank count |
| rows_o | output | 4 | Clamped row address count |
| cols_o | output | 4 | Clamped column address count |
| cs_count_o | output | 4 | Chip-select (side) count |
| data_width_o | output | 16 | Module data width in bits |
| side_size_o | output | SIZE_W | Bytes per side |
| total_size_o | output | SIZE_W+4 | Bytes over all sides |
| warn_o | output | 6 | Bit 0 checksum, bit 1 width, bit 2 CAS unknown, bit 3 CAS raised, bit 4 rows clamped, bit 5 columns clamped |

## Verification
The bench builds the decoder with its defaults: a 64-byte window, a 32-bit side size, clamp limits of 14 rows and 11 columns, and a CAS floor of 2. With the 32-bit side size, the largest clamped geometry, 2^31 bytes per side, fits without truncation. With these limits, nibbles of 15 and 13 drive both clamps. Every refresh selector, both CAS priorities, the floor and the no-bit case are fed through streams that include gaps in the valid strobe. The bench also checks a restart in the middle of a stream, a start that collides with a valid byte, and extra bytes sent after completion.

// File: rtl/spd_cfg_pkg.sv
package spd_cfg_pkg;

    // byte positions inside the presence-data window
    localparam int unsigned POS_ROWS  = 3;
    localparam int unsigned POS_COLS  = 4;
    localparam int unsigned POS_CS    = 5;
    localparam int unsigned POS_WLO   = 6;
    localparam int unsigned POS_WHI   = 7;
    localparam int unsigned POS_REFR  = 12;
    localparam int unsigned POS_BANKS = 17;
    localparam int unsigned POS_CAS   = 18;

    // warning vector bit positions
    localparam int unsigned WARN_W     = 6;
    localparam int unsigned WB_CKSUM   = 0;
    localparam int unsigned WB_WIDTH   = 1;
    localparam int unsigned WB_CASUNK  = 2;
    localparam int unsigned WB_CASLOW  = 3;
    localparam int unsigned WB_ROWCLP  = 4;
    localparam int unsigned WB_COLCLP  = 5;

    typedef struct packed {
        logic [3:0]  rows_nib;
        logic [3:0]  cols_nib;
        logic [3:0]  cs_nib;
        logic [15:0] width;
        logic [6:0]  refr_sel;
        logic [7:0]  banks;
        logic [2:0]  cas_bits;
        logic        pess;
        logic [7:0]  sum;
        logic [7:0]  cks;
    } spd_raw_t;

    function automatic logic [7:0] refresh_code(input logic [6:0] sel);
        logic [7:0] code;
        case (sel)
            7'd1:    code = 8'h07;
            7'd2:    code = 8'h0F;
            7'd3:    code = 8'h43;
            7'd4:    code = 8'h87;
            7'd5:    code = 8'hFF;
            default: code = 8'h21;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/spd_byte_collect.sv
module spd_byte_collect
    import spd_cfg_pkg::*;
#(
    parameter int unsigned NBYTES = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     valid_i,
    input  logic [7:0] byte_i,
    input  logic     pess_i,
    output spd_raw_t raw_o,
    output logic     full_o,
    output logic     done_o
);
    localparam int unsigned IDX_W = $clog2(NBYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             full;
        logic             done;
        spd_raw_t         raw;
    } col_st_t;

    col_st_t st_d, st_q;
    logic    take;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        take      = valid_i && !st_q.full;
        if (start_i) begin
            st_d = '0;
        end else if (take) begin
            if (st_q.idx == IDX_W'(POS_ROWS))  st_d.raw.rows_nib    = byte_i[3:0];
            if (st_q.idx == IDX_W'(POS_COLS))  st_d.raw.cols_nib    = byte_i[3:0];
            if (st_q.idx == IDX_W'(POS_CS))    st_d.raw.cs_nib      = byte_i[3:0];
            if (st_q.idx == IDX_W'(POS_WLO))   st_d.raw.width[7:0]  = byte_i;
            if (st_q.idx == IDX_W'(POS_WHI))   st_d.raw.width[15:8] = byte_i;
            if (st_q.idx == IDX_W'(POS_REFR))  st_d.raw.refr_sel    = byte_i[6:0];
            if (st_q.idx == IDX_W'(POS_BANKS)) st_d.raw.banks       = byte_i;
            if (st_q.idx == IDX_W'(POS_CAS))   st_d.raw.cas_bits    = byte_i[2:0];
            if (st_q.idx == LAST_IDX) begin
                st_d.raw.cks  = byte_i;
                st_d.raw.pess = pess_i;
                st_d.full     = 1'b1;
                st_d.done     = 1'b1;
            end else begin
                st_d.raw.sum  = st_q.raw.sum + byte_i;
            end
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o  = st_q.raw;
    assign full_o = st_q.full;
    assign done_o = st_q.done;

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R2
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(valid_i && !start_i && !st_q.full && st_q.idx == LAST_IDX));

    // R3
    frozen_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !start_i) |=> ($stable(st_q.raw) && st_q.full && !st_q.done));

    // R1
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!st_q.full && st_q.idx == '0 && st_q.raw.sum == 8'd0));

endmodule

// File: rtl/spd_cas_pick.sv
module spd_cas_pick #(
    parameter int unsigned MIN_CAS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bits_i,
    input  logic       pess_i,
    output logic [1:0] cas_o,
    output logic       unknown_o,
    output logic       raised_o
);
    logic [1:0] pick;

    always_comb begin
        pick      = 2'd3;
        unknown_o = 1'b0;
        if (pess_i) begin
            if      (bits_i[2]) pick = 2'd3;
            else if (bits_i[1]) pick = 2'd2;
            else if (bits_i[0]) pick = 2'd1;
            else                unknown_o = 1'b1;
        end else begin
            if      (bits_i[0]) pick = 2'd1;
            else if (bits_i[1]) pick = 2'd2;
            else if (bits_i[2]) pick = 2'd3;
            else                unknown_o = 1'b1;
        end
        raised_o = (pick < 2'(MIN_CAS));
        cas_o    = raised_o ? 2'(MIN_CAS) : pick;
    end

    // R9
    pess_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pess_i && bits_i[2]) |-> (cas_o == 2'd3 && !raised_o));

    // R10
    opt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pess_i && bits_i[0]) |-> (cas_o == 2'(MIN_CAS) && raised_o));

endmodule

// File: rtl/spd_geom.sv
module spd_geom #(
    parameter int unsigned SIZE_W   = 32,
    parameter int unsigned ROW_MAX  = 14,
    parameter int unsigned COL_MAX  = 11,
    parameter int unsigned BUS_LOG2 = 3
) (
    input  logic [3:0]        rows_nib_i,
    input  logic [3:0]        cols_nib_i,
    input  logic [7:0]        banks_i,
    input  logic [3:0]        cs_i,
    output logic [3:0]        rows_o,
    output logic [3:0]        cols_o,
    output logic [1:0]        blog_o,
    output logic [SIZE_W-1:0] side_o,
    output logic [SIZE_W+3:0] total_o,
    output logic              row_clp_o,
    output logic              col_clp_o
);
    localparam int unsigned EXP_W = 7;
    localparam int unsigned TOT_W = SIZE_W + 4;

    logic [EXP_W-1:0] expo;

    always_comb begin
        row_clp_o = (rows_nib_i > 4'(ROW_MAX));
        col_clp_o = (cols_nib_i > 4'(COL_MAX));
        rows_o    = row_clp_o ? 4'(ROW_MAX) : rows_nib_i;
        cols_o    = col_clp_o ? 4'(COL_MAX) : cols_nib_i;
        case (banks_i)
            8'd2:    blog_o = 2'd1;
            8'd4:    blog_o = 2'd2;
            8'd8:    blog_o = 2'd3;
            default: blog_o = 2'd0;
        endcase
        expo    = EXP_W'(rows_o) + EXP_W'(cols_o) + EXP_W'(blog_o) + EXP_W'(BUS_LOG2);
        side_o  = {{(SIZE_W-1){1'b0}}, 1'b1} << expo;
        total_o = TOT_W'(side_o) * TOT_W'(cs_i);
    end

endmodule

// File: rtl/spd_cfg_decoder.sv
module spd_cfg_decoder
    import spd_cfg_pkg::*;
#(
    parameter int unsigned NBYTES  = 64,
    parameter int unsigned SIZE_W  = 32,
    parameter int unsigned ROW_MAX = 14,
    parameter int unsigned COL_MAX = 11,
    parameter int unsigned MIN_CAS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              cas_pess_i,
    output logic              done_o,
    output logic [7:0]        refresh_code_o,
    output logic [1:0]        cas_lat_o,
    output logic [1:0]        bank_log2_o,
    output logic [3:0]        rows_o,
    output logic [3:0]        cols_o,
    output logic [3:0]        cs_count_o,
    output logic [15:0]       data_width_o,
    output logic [SIZE_W-1:0] side_size_o,
    output logic [SIZE_W+3:0] total_size_o,
    output logic [5:0]        warn_o
);
    spd_raw_t          raw;
    logic              full;
    logic [1:0]        cas;
    logic              cas_unk, cas_low;
    logic [3:0]        rows, cols;
    logic [1:0]        blog;
    logic [SIZE_W-1:0] side;
    logic [SIZE_W+3:0] total;
    logic              row_clp, col_clp;
    logic [WARN_W-1:0] warn;

    spd_byte_collect #(.NBYTES(NBYTES)) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (byte_vld_i),
        .byte_i  (byte_i),
        .pess_i  (cas_pess_i),
        .raw_o   (raw),
        .full_o  (full),
        .done_o  (done_o)
    );

    spd_cas_pick #(.MIN_CAS(MIN_CAS)) u_cas (
        .clk       (clk),
        .rst_n     (rst_n),
        .bits_i    (raw.cas_bits),
        .pess_i    (raw.pess),
        .cas_o     (cas),
        .unknown_o (cas_unk),
        .raised_o  (cas_low)
    );

    spd_geom #(
        .SIZE_W  (SIZE_W),
        .ROW_MAX (ROW_MAX),
        .COL_MAX (COL_MAX),
        .BUS_LOG2(3)
    ) u_geom (
        .rows_nib_i (raw.rows_nib),
        .cols_nib_i (raw.cols_nib),
        .banks_i    (raw.banks),
        .cs_i       (raw.cs_nib),
        .rows_o     (rows),
        .cols_o     (cols),
        .blog_o     (blog),
        .side_o     (side),
        .total_o    (total),
        .row_clp_o  (row_clp),
        .col_clp_o  (col_clp)
    );

    always_comb begin
        warn            = '0;
        warn[WB_CKSUM]  = (raw.sum != raw.cks);
        warn[WB_WIDTH]  = (raw.width != 16'd64) && (raw.width != 16'd72);
        warn[WB_CASUNK] = cas_unk;
        warn[WB_CASLOW] = cas_low;
        warn[WB_ROWCLP] = row_clp;
        warn[WB_COLCLP] = col_clp;
    end

    always_comb begin
        refresh_code_o = '0;
        cas_lat_o      = '0;
        bank_log2_o    = '0;
        rows_o         = '0;
        cols_o         = '0;
        cs_count_o     = '0;
        data_width_o   = '0;
        side_size_o    = '0;
        total_size_o   = '0;
        warn_o         = '0;
        if (full) begin
            refresh_code_o = refresh_code(raw.refr_sel);
            cas_lat_o      = cas;
            bank_log2_o    = blog;
            rows_o         = rows;
            cols_o         = cols;
            cs_count_o     = raw.cs_nib;
            data_width_o   = raw.width;
            side_size_o    = side;
            total_size_o   = total;
            warn_o         = warn;
        end
    end

    // R5
    out_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rows_o <= 4'(ROW_MAX) && cols_o <= 4'(COL_MAX) && cas_lat_o >= 2'(MIN_CAS)));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_i) |-> (total_size_o == '0 && warn_o == '0 && !done_o));

endmodule

// File: tb/tb_spd_cfg_decoder.sv
module tb_spd_cfg_decoder;
    localparam int unsigned SIZE_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              byte_vld_i = 1'b0;
    logic [7:0]        byte_i = '0;
    logic              cas_pess_i = 1'b0;
    logic              done_o;
    logic [7:0]        refresh_code_o;
    logic [1:0]        cas_lat_o;
    logic [1:0]        bank_log2_o;
    logic [3:0]        rows_o, cols_o, cs_count_o;
    logic [15:0]       data_width_o;
    logic [SIZE_W-1:0] side_size_o;
    logic [SIZE_W+3:0] total_size_o;
    logic [5:0]        warn_o;

    spd_cfg_decoder dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .cas_pess_i(cas_pess_i), .done_o(done_o),
        .refresh_code_o(refresh_code_o), .cas_lat_o(cas_lat_o),
        .bank_log2_o(bank_log2_o), .rows_o(rows_o), .cols_o(cols_o),
        .cs_count_o(cs_count_o), .data_width_o(data_width_o),
        .side_size_o(side_size_o), .total_size_o(total_size_o), .warn_o(warn_o)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [7:0]  refr;
        logic [1:0]  cas;
        logic [1:0]  blog;
        logic [3:0]  rows;
        logic [3:0]  cols;
        logic [3:0]  cs;
        logic [15:0] width;
        logic [31:0] side;
        logic [35:0] total;
        logic [5:0]  warn;
    } exp_t;

    exp_t       sb[$];
    exp_t       last_exp;
    logic [7:0] img [64];
    int         total_chk = 0;
    int         bad_chk = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total_chk++;
        if (act != exp) begin
            bad_chk++;
            $display("FAIL %s %s: got %0d want %0d", req, what, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        chk("R7",  "refresh code", refresh_code_o, e.refr);
        chk("R9",  "cas latency", cas_lat_o, e.cas);
        chk("R8",  "bank log2", bank_log2_o, e.blog);
        chk("R5",  "rows", rows_o, e.rows);
        chk("R5",  "cols", cols_o, e.cols);
        chk("R5",  "chip selects", cs_count_o, e.cs);
        chk("R6",  "data width", data_width_o, e.width);
        chk("R11", "side size", side_size_o, e.side);
        chk("R11", "total size", total_size_o, e.total);
        chk("R4",  "checksum flag", warn_o[0], e.warn[0]);
        chk("R6",  "width flag", warn_o[1], e.warn[1]);
        chk("R9",  "cas unknown flag", warn_o[2], e.warn[2]);
        chk("R10", "cas raised flag", warn_o[3], e.warn[3]);
        chk("R5",  "row clamp flag", warn_o[4], e.warn[4]);
        chk("R5",  "col clamp flag", warn_o[5], e.warn[5]);
    endtask

    function automatic exp_t model(input bit pess);
        exp_t        e;
        logic [7:0]  s;
        int          r, c, bl, cl;
        longint      side;
        s = 8'd0;
        for (int i = 0; i < 63; i++) s = s + img[i];
        e      = '0;
        e.warn[0] = (s != img[63]);
        r = img[3] & 15;  c = img[4] & 15;
        e.warn[4] = (r > 14); if (r > 14) r = 14;
        e.warn[5] = (c > 11); if (c > 11) c = 11;
        e.rows = 4'(r); e.cols = 4'(c);
        e.cs    = img[5][3:0];
        e.width = {img[7], img[6]};
        e.warn[1] = !(e.width == 16'd64 || e.width == 16'd72);
        case (img[12] & 8'h7F)
            8'd1: e.refr = 8'h07;
            8'd2: e.refr = 8'h0F;
            8'd3: e.refr = 8'h43;
            8'd4: e.refr = 8'h87;
            8'd5: e.refr = 8'hFF;
            default: e.refr = 8'h21;
        endcase
        case (img[17])
            8'd2: bl = 1;
            8'd4: bl = 2;
            8'd8: bl = 3;
            default: bl = 0;
        endcase
        e.blog = 2'(bl);
        cl = 3;
        if (pess) begin
            if (img[18][2]) cl = 3; else if (img[18][1]) cl = 2;
            else if (img[18][0]) cl = 1; else e.warn[2] = 1'b1;
        end else begin
            if (img[18][0]) cl = 1; else if (img[18][1]) cl = 2;
            else if (img[18][2]) cl = 3; else e.warn[2] = 1'b1;
        end
        if (cl < 2) begin cl = 2; e.warn[3] = 1'b1; end
        e.cas   = 2'(cl);
        side    = 64'd1 << (r + c + bl + 3);
        e.side  = 32'(side);
        e.total = 36'(side * longint'(e.cs));
        return e;
    endfunction

    task automatic mk(input int r, input int c, input int cs, input int w,
                      input int refr, input int banks, input int cas, input bit good);
        logic [7:0] s;
        for (int i = 0; i < 64; i++) img[i] = 8'((i * 37 + 11) & 255);
        img[3]  = {4'hA, 4'(r)};
        img[4]  = {4'h5, 4'(c)};
        img[5]  = {4'h3, 4'(cs)};
        img[6]  = 8'(w);
        img[7]  = 8'(w >> 8);
        img[12] = 8'(refr);
        img[17] = 8'(banks);
        img[18] = 8'(cas);
        s = 8'd0;
        for (int i = 0; i < 63; i++) s = s + img[i];
        img[63] = good ? s : s + 8'd1;
    endtask

    task automatic drive_bytes(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk); byte_vld_i = 1'b0; byte_i = 8'hEE;
            end
            @(negedge clk); byte_vld_i = 1'b1; byte_i = img[i];
        end
        @(negedge clk); byte_vld_i = 1'b0;
    endtask

    task automatic feed(input bit pess, input bit gaps);
        last_exp = model(pess);
        sb.push_back(last_exp);
        cas_pess_i = pess;
        drive_bytes(64, gaps);
        repeat (2) @(negedge clk);
        chk("R2", "done pulse seen", sb.size(), 0);
        compare(last_exp);
    endtask

    task automatic clear();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk("R1", "total after start", total_size_o, 0);
        chk("R1", "warn after start", warn_o, 0);
        chk("R1", "refresh after start", refresh_code_o, 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) chk("R2", "unexpected done pulse", 1, 0);
            else compare(sb.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk("R2", "watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", done_o, 0);
        chk("R1", "total after reset", total_size_o, 0);
        chk("R1", "warn after reset", warn_o, 0);

        // R9 R7 R8 R11: typical module, lowest CAS wins
        mk(12, 9, 2, 64, 1, 4, 3'b110, 1'b1);
        feed(1'b0, 1'b0);
        // R2: results held
        repeat (3) @(negedge clk);
        compare(last_exp);
        clear();

        // R9 pessimistic on the same image
        feed(1'b1, 1'b1);
        clear();

        // R5 clamps, R6 width flag, R4 bad checksum, R10 floor, R7 masked selector
        mk(15, 13, 1, 80, 8'h85, 8, 3'b001, 1'b0);
        feed(1'b0, 1'b0);
        // R3 extra bytes ignored
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); byte_vld_i = 1'b1; byte_i = 8'(i * 51);
        end
        @(negedge clk); byte_vld_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3", "no pending after extras", sb.size(), 0);
        compare(last_exp);
        clear();

        // R9 no bit set, R8 odd bank count, zero chip selects
        mk(4, 8, 0, 72, 9, 3, 3'b000, 1'b1);
        feed(1'b1, 1'b0);
        clear();

        // R10 pessimistic with only bit 0
        mk(11, 10, 1, 72, 3, 2, 3'b001, 1'b1);
        feed(1'b1, 1'b1);
        clear();

        // R1 start colliding with a valid byte, then a full stream
        @(negedge clk); start_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'hAA;
        @(negedge clk); start_i = 1'b0; byte_vld_i = 1'b0;
        mk(13, 10, 2, 72, 2, 4, 3'b100, 1'b1);
        feed(1'b0, 1'b1);
        clear();

        // R1 partial stream discarded by start
        mk(9, 9, 3, 64, 4, 8, 3'b010, 1'b0);
        drive_bytes(30, 1'b0);
        chk("R1", "no done on partial", done_o, 0);
        clear();
        mk(10, 8, 1, 64, 0, 2, 3'b011, 1'b1);
        feed(1'b1, 1'b0);
        clear();

        // R7 walk all selector values
        for (int k = 0; k < 8; k++) begin
            mk(12, 10, 1, 64, k, 4, 3'b110, 1'b1);
            feed(k[0], 1'b0);
            clear();
        end

        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

endmodule